// File: doc/BRIEF.md
# Patchable Microcode Sequencer

This block expands one complex-instruction opcode into a run of micro-operations. A start request, which is taken only while the block is idle, looks the opcode up in a writable entry table to find the first triad. A triad is one control-store word. It carries three micro-op slots and a sequencing word. The block fetches a triad, issues its non-empty slots one at a time over a valid/ready handshake, and then uses the sequencing word to pick the next triad or to finish the instruction.

The control store is a ROM-like array and a small patch RAM, and both are loaded through a configuration write port. Before each ROM fetch, the fetch address is compared with a bank of programmable match entries. On a hit, the triad comes from the patch RAM slot that the entry names, and fetching continues in patch space from that slot. A sequencing word can also jump straight into patch space, or jump from there back into ROM space.

Top module: `ucode_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `uop_valid` are all low.
- R2: A `start` while idle reads the entry table at `opcode` and begins fetching at that triad address. `busy` stays high from the cycle after `start` until the instruction ends.
- R3: Triad layout: slot 0 is bits [UOP_W-1:0], slot 1 is the next UOP_W bits, and slot 2 is the UOP_W bits after that. Above them sits a UA_W-bit target field, and the top 2 bits hold the mode. Slots are issued in the order 0, 1, 2. A slot equal to zero is a no-op and is never presented.
- R4: Mode 00 goes on to the next address in the current space. Mode 01 jumps to the target in ROM space. Mode 10 ends the instruction. Mode 11 jumps to patch slot target[PR_IDX_W-1:0]. A ROM address at or above the implemented ROM depth reads as an end-marked triad with no micro-ops.
- R5: A ROM fetch whose address equals a valid match entry is served from the patch RAM slot that the entry holds. Later sequential fetches then continue in patch space.
- R6: When several valid match entries hold the same address, the entry with the lowest number supplies the patch slot.
- R7: While `uop_valid` is high and `uop_ready` is low, `uop_valid` and `uop_data` hold. No later triad is fetched before every slot of the current triad has been accepted.
- R8: `done` is high for exactly one cycle, in the cycle right after the last accepted micro-op of an end-marked triad. `busy` is low in that same cycle.
- R9: A `start` while `busy` is high is ignored. It causes no extra micro-ops and no extra `done`.
- R10: Writes to a match entry while `busy` is high are dropped. Writes while idle take effect.
- R11: The meaning of `cfg_sel` is: 0 writes a ROM triad at `cfg_addr`, 1 writes a patch RAM triad, and 2 writes the entry table (the low UA_W bits of the data). 3 writes match entry `cfg_addr`, with the data taken as {valid, ROM address (UA_W bits), patch slot (PR_IDX_W bits)} from the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | OP_W | Opcode indexing the entry table |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| uop_valid | output | 1 | A micro-op is presented |
| uop_ready | input | 1 | Downstream accepts the micro-op |
| uop_data | output | UOP_W | Presented micro-op |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_addr | input | ROM_IDX_W | Configuration index |
| cfg_wdata | input | 3*UOP_W+2+UA_W | Configuration data |

## Verification
The bench builds the block with ROM_IDX_W = 8 and leaves every other parameter at its default. A 256-triad ROM is quick to load, yet it is still wide enough for the full 8-bit entry-table index. It also puts the 13-bit address 0x1000 outside the implemented ROM, so the out-of-range end-triad rule can be reached. With eight match entries, two of them can overlap on one address to test priority, and a patch-space run can walk sequentially across adjacent patch slots.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    SQ_NEXT  = 2'b00,
    SQ_JUMP  = 2'b01,
    SQ_END   = 2'b10,
    SQ_PATCH = 2'b11
  } sq_mode_e;

  typedef enum logic [1:0] {
    CS_ROM   = 2'd0,
    CS_PRAM  = 2'd1,
    CS_ENTRY = 2'd2,
    CS_MATCH = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ISSUE = 2'd2
  } seq_state_e;

  // Lowest pending slot of a three-slot mask.
  function automatic logic [1:0] first_slot(input logic [2:0] m);
    if (m[0])      return 2'd0;
    else if (m[1]) return 2'd1;
    else           return 2'd2;
  endfunction

endpackage

// File: rtl/mcs_match.sv
module mcs_match #(
  parameter int UA_W     = 13,
  parameter int PR_IDX_W = 5,
  parameter int N_MATCH  = 8,
  localparam int MW      = $clog2(N_MATCH),
  localparam int MATCH_W = 1 + UA_W + PR_IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [MW-1:0]       wr_entry,
  input  logic [MATCH_W-1:0]  wr_data,
  input  logic                lock,
  input  logic [UA_W-1:0]     lookup_addr,
  output logic                hit,
  output logic [PR_IDX_W-1:0] hit_idx
);

  logic [N_MATCH-1:0]  vld_q;
  logic [UA_W-1:0]     addr_q [N_MATCH];
  logic [PR_IDX_W-1:0] idx_q  [N_MATCH];
  logic [N_MATCH-1:0]  raw_hit;
  logic [N_MATCH-1:0]  grant;
  logic                wr_take;

  assign wr_take = wr_en && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N_MATCH; i++) begin
        addr_q[i] <= '0;
        idx_q[i]  <= '0;
      end
    end else if (wr_take) begin
      vld_q[wr_entry]  <= wr_data[MATCH_W-1];
      addr_q[wr_entry] <= wr_data[PR_IDX_W +: UA_W];
      idx_q[wr_entry]  <= wr_data[PR_IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < N_MATCH; g++) begin : g_cmp
    assign raw_hit[g] = vld_q[g] && (addr_q[g] == lookup_addr);
  end

  // Isolate the lowest set bit: lowest entry number has priority.
  assign grant = raw_hit & (~raw_hit + N_MATCH'(1));
  assign hit   = |raw_hit;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N_MATCH; i++)
      if (grant[i]) hit_idx = hit_idx | idx_q[i];
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (hit == (grant != '0))); // R6
  AST_LOCKED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(vld_q)); // R10

endmodule

// File: rtl/mcs_store.sv
module mcs_store
  import mcs_pkg::*;
#(
  parameter int UOP_W     = 16,
  parameter int UA_W      = 13,
  parameter int ROM_IDX_W = 9,
  parameter int PR_IDX_W  = 5,
  parameter int OP_W      = 8,
  localparam int TRIAD_W  = 3*UOP_W + 2 + UA_W
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [1:0]           sel,
  input  logic [ROM_IDX_W-1:0] waddr,
  input  logic [TRIAD_W-1:0]   wdata,
  input  logic [OP_W-1:0]      opcode,
  output logic [UA_W-1:0]      entry_addr,
  input  logic                 rd_patch,
  input  logic [UA_W-1:0]      rd_rom_addr,
  input  logic [PR_IDX_W-1:0]  rd_pidx,
  output logic [TRIAD_W-1:0]   rd_triad
);

  localparam int ROM_DEPTH = 1 << ROM_IDX_W;
  localparam int PR_DEPTH  = 1 << PR_IDX_W;
  localparam int ENT_DEPTH = 1 << OP_W;

  logic [TRIAD_W-1:0] rom_q  [ROM_DEPTH];
  logic [TRIAD_W-1:0] pram_q [PR_DEPTH];
  logic [UA_W-1:0]    ent_q  [ENT_DEPTH];
  logic               rom_in_range;
  logic [TRIAD_W-1:0] end_triad;

  always_ff @(posedge clk) begin
    if (we) begin
      case (cfg_sel_e'(sel))
        CS_ROM:   rom_q[waddr]                 <= wdata;
        CS_PRAM:  pram_q[waddr[PR_IDX_W-1:0]]  <= wdata;
        CS_ENTRY: ent_q[waddr[OP_W-1:0]]       <= wdata[UA_W-1:0];
        default:  ;
      endcase
    end
  end

  assign entry_addr   = ent_q[opcode];
  assign rom_in_range = (rd_rom_addr >> ROM_IDX_W) == '0;
  assign end_triad    = {SQ_END, {(TRIAD_W-2){1'b0}}};

  always_comb begin
    if (rd_patch)          rd_triad = pram_q[rd_pidx];
    else if (rom_in_range) rd_triad = rom_q[rd_rom_addr[ROM_IDX_W-1:0]];
    else                   rd_triad = end_triad;
  end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import mcs_pkg::*;
#(
  parameter int UOP_W     = 16,
  parameter int UA_W      = 13,
  parameter int ROM_IDX_W = 9,
  parameter int PR_IDX_W  = 5,
  parameter int N_MATCH   = 8,
  parameter int OP_W      = 8,
  localparam int TRIAD_W  = 3*UOP_W + 2 + UA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [OP_W-1:0]      opcode,
  output logic                 busy,
  output logic                 done,
  output logic                 uop_valid,
  input  logic                 uop_ready,
  output logic [UOP_W-1:0]     uop_data,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [ROM_IDX_W-1:0] cfg_addr,
  input  logic [TRIAD_W-1:0]   cfg_wdata
);

  localparam int MW      = $clog2(N_MATCH);
  localparam int MATCH_W = 1 + UA_W + PR_IDX_W;
  localparam int SEQ_LSB = 3*UOP_W;

  // Next fetch location {patch_space, address} from a sequencing word.
  function automatic logic [UA_W:0] next_loc(input logic [1:0] mode,
                                             input logic [UA_W-1:0] tgt,
                                             input logic [UA_W-1:0] pc,
                                             input logic in_patch);
    logic [UA_W-1:0] pmask;
    logic [UA_W-1:0] inc;
    pmask = UA_W'((1 << PR_IDX_W) - 1);
    inc   = pc + UA_W'(1);
    case (sq_mode_e'(mode))
      SQ_JUMP:  return {1'b0, tgt};
      SQ_PATCH: return {1'b1, tgt & pmask};
      default:  return {in_patch, in_patch ? (inc & pmask) : inc};
    endcase
  endfunction

  seq_state_e          state_q;
  logic [UA_W-1:0]     pc_q;
  logic                in_patch_q;
  logic [TRIAD_W-1:0]  triad_q;
  logic [2:0]          mask_q;
  logic                done_q;

  logic [UA_W-1:0]     entry_addr;
  logic [TRIAD_W-1:0]  rd_triad;
  logic                fetch_hit;
  logic [PR_IDX_W-1:0] hit_idx;
  logic                rd_patch;
  logic [PR_IDX_W-1:0] rd_pidx;
  logic [1:0]          slot;
  logic                acc;
  logic [2:0]          mask_after;
  logic                triad_done;
  logic [1:0]          cur_mode;
  logic [UA_W-1:0]     cur_tgt;
  logic [2:0]          fill_mask;

  mcs_store #(
    .UOP_W(UOP_W), .UA_W(UA_W), .ROM_IDX_W(ROM_IDX_W),
    .PR_IDX_W(PR_IDX_W), .OP_W(OP_W)
  ) u_store (
    .clk(clk), .we(cfg_we), .sel(cfg_sel), .waddr(cfg_addr), .wdata(cfg_wdata),
    .opcode(opcode), .entry_addr(entry_addr),
    .rd_patch(rd_patch), .rd_rom_addr(pc_q), .rd_pidx(rd_pidx), .rd_triad(rd_triad)
  );

  mcs_match #(
    .UA_W(UA_W), .PR_IDX_W(PR_IDX_W), .N_MATCH(N_MATCH)
  ) u_match (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && (cfg_sel_e'(cfg_sel) == CS_MATCH)),
    .wr_entry(cfg_addr[MW-1:0]), .wr_data(cfg_wdata[MATCH_W-1:0]),
    .lock(busy), .lookup_addr(pc_q), .hit(fetch_hit), .hit_idx(hit_idx)
  );

  assign rd_patch   = in_patch_q || fetch_hit;
  assign rd_pidx    = in_patch_q ? pc_q[PR_IDX_W-1:0] : hit_idx;
  assign fill_mask  = {rd_triad[2*UOP_W +: UOP_W] != '0,
                       rd_triad[UOP_W +: UOP_W]   != '0,
                       rd_triad[0 +: UOP_W]       != '0};

  assign cur_mode   = triad_q[TRIAD_W-1 -: 2];
  assign cur_tgt    = triad_q[SEQ_LSB +: UA_W];
  assign slot       = first_slot(mask_q);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign uop_valid  = (state_q == ST_ISSUE) && (mask_q != '0);
  assign acc        = uop_valid && uop_ready;
  assign mask_after = acc ? (mask_q & ~(3'b001 << slot)) : mask_q;
  assign triad_done = (state_q == ST_ISSUE) && (mask_after == '0);

  always_comb begin
    case (slot)
      2'd0:    uop_data = triad_q[0 +: UOP_W];
      2'd1:    uop_data = triad_q[UOP_W +: UOP_W];
      default: uop_data = triad_q[2*UOP_W +: UOP_W];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pc_q       <= '0;
      in_patch_q <= 1'b0;
      triad_q    <= '0;
      mask_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          pc_q       <= entry_addr;
          in_patch_q <= 1'b0;
          state_q    <= ST_FETCH;
        end
        ST_FETCH: begin
          triad_q <= rd_triad;
          mask_q  <= fill_mask;
          if (!in_patch_q && fetch_hit) begin
            in_patch_q <= 1'b1;
            pc_q       <= UA_W'(hit_idx);
          end
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          mask_q <= mask_after;
          if (triad_done) begin
            if (sq_mode_e'(cur_mode) == SQ_END) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              {in_patch_q, pc_q} <= next_loc(cur_mode, cur_tgt, pc_q, in_patch_q);
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_UOP: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_data))); // R7
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> busy); // R2
  AST_NO_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> (uop_data != '0)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q == ST_ISSUE && !triad_done) |=> $stable(pc_q)); // R9

endmodule

// File: tb/ucode_sequencer_bench.sv
module ucode_sequencer_bench;

  localparam int UOP_W = 16;
  localparam int UA_W  = 13;
  localparam int RIW   = 8;
  localparam int TW    = 3*UOP_W + 2 + UA_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [7:0]      opcode = '0;
  logic            busy, done, uop_valid;
  logic            uop_ready = 1'b1;
  logic [15:0]     uop_data;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_sel = '0;
  logic [RIW-1:0]  cfg_addr = '0;
  logic [TW-1:0]   cfg_wdata = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ucode_sequencer #(.ROM_IDX_W(RIW)) u_ucode_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .busy(busy), .done(done), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_data(uop_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  // {opcode, count, uop0..uop4}
  localparam logic [91:0] VEC [5] = '{
    {8'h01, 4'd4, 16'h1001, 16'h1002, 16'h1003, 16'h1004, 16'h0000},
    {8'h02, 4'd5, 16'h2001, 16'h2003, 16'h2040, 16'h2041, 16'h2042},
    {8'h03, 4'd4, 16'h3A01, 16'h3A02, 16'h3A05, 16'h3050, 16'h0000},
    {8'h04, 4'd3, 16'h4001, 16'h4801, 16'h4802, 16'h0000, 16'h0000},
    {8'h05, 4'd1, 16'h5B11, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
  };

  logic [15:0] got [16];
  int got_n, done_cnt, done_it, last_it, hold_bad, done_busy;

  function automatic logic [TW-1:0] tri3(input logic [15:0] a, input logic [15:0] b,
                                         input logic [15:0] c, input logic [1:0] m,
                                         input logic [12:0] t);
    return {m, t, c, b, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [RIW-1:0] a, input logic [TW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [TW-1:0] mrec(input logic v, input logic [12:0] a, input logic [4:0] i);
    return TW'({v, a, i});
  endfunction

  // inj: 0 none, 1 start during run, 2 match write during run
  task automatic run_op(input logic [7:0] op, input bit stall, input int inj, input int inj_at);
    logic pv, pr;
    logic [15:0] pd;
    got_n = 0; done_cnt = 0; done_it = -1; last_it = -1; hold_bad = 0; done_busy = 0;
    pv = 1'b0; pr = 1'b1; pd = '0;
    @(negedge clk);
    start = 1'b1; opcode = op;
    for (int it = 0; it < 60; it++) begin
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
      if (pv && !pr && !(uop_valid && uop_data == pd)) hold_bad++;
      if (done) begin
        done_cnt++;
        if (done_it < 0) done_it = it;
        if (busy) done_busy++;
      end
      if (it == inj_at && inj == 1) begin start = 1'b1; opcode = 8'h01; end
      if (it == inj_at && inj == 2) begin
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_addr = '0; cfg_wdata = mrec(1'b1, 13'd10, 5'd4);
      end
      uop_ready = stall ? ((it % 3) != 1) : 1'b1;
      if (uop_valid && uop_ready) begin
        if (got_n < 16) got[got_n] = uop_data;
        got_n++;
        last_it = it;
      end
      pv = uop_valid; pr = uop_ready; pd = uop_data;
    end
    start = 1'b0; cfg_we = 1'b0; uop_ready = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !uop_valid, "R1", "outputs in reset", {busy, done, uop_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !uop_valid, "R1", "outputs after reset", {busy, done, uop_valid}, 0);

    // Load control store through the configuration port (R11 encoding)
    cfg_write(2'd0, 8'd10, tri3(16'h1001, 16'h1002, 16'h1003, 2'b00, 13'd0));
    cfg_write(2'd0, 8'd11, tri3(16'h1004, 16'h0,    16'h0,    2'b10, 13'd0));
    cfg_write(2'd0, 8'd20, tri3(16'h2001, 16'h0,    16'h2003, 2'b01, 13'd40));
    cfg_write(2'd0, 8'd40, tri3(16'h2040, 16'h2041, 16'h2042, 2'b10, 13'd0));
    cfg_write(2'd0, 8'd30, tri3(16'h3001, 16'h3002, 16'h3003, 2'b10, 13'd0));
    cfg_write(2'd0, 8'd50, tri3(16'h3050, 16'h0,    16'h0,    2'b10, 13'd0));
    cfg_write(2'd0, 8'd60, tri3(16'h4001, 16'h0,    16'h0,    2'b11, 13'd8));
    cfg_write(2'd0, 8'd70, tri3(16'h5001, 16'h0,    16'h0,    2'b10, 13'd0));
    cfg_write(2'd1, 8'd4,  tri3(16'h3A01, 16'h3A02, 16'h0,    2'b00, 13'd0));
    cfg_write(2'd1, 8'd5,  tri3(16'h3A05, 16'h0,    16'h0,    2'b01, 13'd50));
    cfg_write(2'd1, 8'd8,  tri3(16'h4801, 16'h4802, 16'h0,    2'b10, 13'd0));
    cfg_write(2'd1, 8'd10, tri3(16'h5A10, 16'h0,    16'h0,    2'b10, 13'd0));
    cfg_write(2'd1, 8'd11, tri3(16'h5B11, 16'h0,    16'h0,    2'b10, 13'd0));
    cfg_write(2'd3, 8'd3, mrec(1'b1, 13'd30, 5'd4));
    cfg_write(2'd3, 8'd6, mrec(1'b1, 13'd70, 5'd10));
    cfg_write(2'd3, 8'd2, mrec(1'b1, 13'd70, 5'd11));
    cfg_write(2'd2, 8'h01, TW'(13'd10));
    cfg_write(2'd2, 8'h02, TW'(13'd20));
    cfg_write(2'd2, 8'h03, TW'(13'd30));
    cfg_write(2'd2, 8'h04, TW'(13'd60));
    cfg_write(2'd2, 8'h05, TW'(13'd70));
    cfg_write(2'd2, 8'h07, TW'(13'd40));
    cfg_write(2'd2, 8'h08, TW'(13'h1000));

    // Table walk: R2 R3 R4 (rows 1,2,4), R5 (rows 3,4), R6 (row 5), R8
    for (int r = 0; r < 5; r++) begin
      string req;
      req = (r == 2) ? "R5" : (r == 4) ? "R6" : (r == 3) ? "R4" : "R3";
      run_op(VEC[r][91:84], 1'b0, 0, -1);
      chk(got_n == int'(VEC[r][83:80]), req, "uop count", got_n, VEC[r][83:80]);
      for (int k = 0; k < int'(VEC[r][83:80]); k++)
        chk(got[k] == VEC[r][79-16*k -: 16], req, "uop value", got[k], VEC[r][79-16*k -: 16]);
      chk(done_cnt == 1 && done_it == last_it + 1, "R8", "done timing", done_it, last_it + 1);
      chk(done_busy == 0, "R8", "busy low with done", done_busy, 0);
    end

    // R7: backpressure keeps data and order
    run_op(8'h02, 1'b1, 0, -1);
    chk(hold_bad == 0, "R7", "hold under stall", hold_bad, 0);
    chk(got_n == 5 && got[2] == 16'h2040 && got[4] == 16'h2042, "R7", "stream under stall", got[4], 16'h2042);

    // R9: start while busy ignored
    run_op(8'h02, 1'b0, 1, 2);
    chk(got_n == 5 && done_cnt == 1, "R9", "extra start ignored", got_n, 5);
    chk(!busy, "R9", "idle at end", busy, 0);

    // R10: match write while busy dropped, write while idle takes effect
    run_op(8'h01, 1'b0, 2, 2);
    run_op(8'h01, 1'b0, 0, -1);
    chk(got_n == 4 && got[0] == 16'h1001, "R10", "busy match write dropped", got[0], 16'h1001);
    cfg_write(2'd3, 8'd0, mrec(1'b1, 13'd10, 5'd4));
    run_op(8'h01, 1'b0, 0, -1);
    chk(got_n == 4 && got[0] == 16'h3A01, "R10", "idle match write used", got[0], 16'h3A01);
    cfg_write(2'd3, 8'd0, mrec(1'b0, 13'd0, 5'd0));

    // R11 / R2: entry table written for opcode 7 lands mid-ROM
    run_op(8'h07, 1'b0, 0, -1);
    chk(got_n == 3 && got[0] == 16'h2040, "R11", "entry table write", got[0], 16'h2040);

    // R4: address beyond implemented ROM ends with no micro-ops
    run_op(8'h08, 1'b0, 0, -1);
    chk(got_n == 0 && done_cnt == 1, "R4", "out-of-range end triad", got_n, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule